// File: doc/BRIEF.md
# Qualified Threshold Interrupt Controller

This block watches a stream of converted samples from 48 analog channels. Each sample arrives with its channel number and is compared against that channel's own low and high limits. A channel's flag rises only after it has delivered a programmed number of consecutive in-range samples, so single noisy readings never reach the host. Flags are gathered into three 16-bit status words that software clears one bit at a time, and any set flag of an enabled channel drives the interrupt line.

A second counter qualifies an acquisition trigger. One channel is picked as the trigger source. While trigger arming is on, that channel must be in range a programmed number of consecutive times before a start-of-acquisition pulse is issued. The start pulse wipes all pending flags, so the interrupt line drops as acquisition begins. Both run lengths share one 8-bit filter register on a small 16-bit register bus.

Top module: `tqi_ctrl`

## Requirements
- R1: A sample is in range when lim_lo <= sample <= lim_hi, all three read as signed 16-bit values; a sample one step outside either limit is out of range, and a sample whose channel number is 48 or above has no effect.
- R2: With the flag run length N in filter bits 3:0, a channel's status bit sets after the edge of the N-th consecutive in-range sample of that channel; an out-of-range sample restarts the run, and once reached, every further in-range sample sets the bit again.
- R3: A run length of 0 (flag or trigger) behaves as 1, so one in-range sample qualifies.
- R4: A channel whose ch_enable bit is 0 never gets its status bit set, and its samples leave its run count unchanged.
- R5: Status words are read at address 0x18 (channels 15..0), 0x1A (channels 31..16) and 0x1C (channels 47..32), bit k of a word holding the lowest channel of the word plus k.
- R6: Writing a status word clears each bit written as 1 and leaves bits written as 0; if a bit is set by a new event in the same cycle as its clear, it stays set.
- R7: irq is high exactly when some status bit of a channel with ch_enable high is set; address 0x20 reads bit 0 = irq, bit 1 = busy_in, bit 2 = acq_en, bits 15..3 = 0; unmapped addresses read 0.
- R8: While acq_en is high, the channel named by trig_ch must give M consecutive in-range samples (M in filter bits 7:4) to issue a one-cycle acq_start, which appears in the cycle after the qualifying sample; the run then restarts from zero; the trigger run ignores ch_enable and holds while acq_en is low.
- R9: The edge that qualifies the trigger clears every status bit, except bits set by events on that same edge.
- R10: The filter register is written and read at address 0x16, low byte only, upper read bits 0.
- R11: After reset all status bits, the filter register, all run counts, irq and acq_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | A sample is presented this cycle |
| sample_ch | input | 6 | Channel number of the sample |
| sample_data | input | 16 | Signed sample value |
| lim_lo | input | 768 | Signed low limit per channel, channel i at bits 16i+15..16i |
| lim_hi | input | 768 | Signed high limit per channel, same packing |
| ch_enable | input | 48 | Threshold detection enable per channel |
| trig_ch | input | 6 | Channel used as acquisition trigger |
| acq_en | input | 1 | Arms the trigger qualifier |
| busy_in | input | 1 | Busy indication mirrored in the status word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| acq_start | output | 1 | One-cycle start-of-acquisition pulse |

## Verification
A corrupted run counter shows up as a status bit appearing one sample too early or too late, visible on the status word read in the cycle after the offending sample. A stuck or dropped status bit is seen on irq and on the read of its word right after the edge, while a mis-decoded clear shows as a neighbouring bit vanishing after the write. A wrong trigger count moves acq_start by whole samples and leaves flags alive that should have been wiped on the same edge.

// File: rtl/tqi_pkg.sv
`timescale 1ns/1ps
// Package tqi_pkg: register addresses and the filter field layout shared by
// the qualified threshold interrupt controller. Assumes byte addressing of
// 16-bit registers.
package tqi_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] FILT_ADDR = 8'h16;
    localparam logic [ADDR_W-1:0] STAT_BASE = 8'h18;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h20;

    typedef struct packed {
        logic [3:0] trig_need;
        logic [3:0] flag_need;
    } filt_t;
endpackage

// File: rtl/tqi_range_cmp.sv
`timescale 1ns/1ps
// Module tqi_range_cmp: selects the limits of the sample's channel and tests
// lo <= data <= hi as signed values. Assumes limits are packed per channel.
// Channel numbers at or above NUM_CH report ch_ok = 0 and never in range.
module tqi_range_cmp #(
    parameter int NUM_CH   = 48,
    parameter int SAMPLE_W = 16,
    parameter int CH_W     = 6
) (
    input  logic [CH_W-1:0]            ch,
    input  logic [SAMPLE_W-1:0]        data,
    input  logic [NUM_CH*SAMPLE_W-1:0] lim_lo,
    input  logic [NUM_CH*SAMPLE_W-1:0] lim_hi,
    output logic                       ch_ok,
    output logic                       in_range
);
    logic signed [SAMPLE_W-1:0] lo_sel;
    logic signed [SAMPLE_W-1:0] hi_sel;

    // Pick the limit pair belonging to the addressed channel.
    always_comb begin
        lo_sel = '0;
        hi_sel = '0;
        ch_ok  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch == CH_W'(i)) begin
                lo_sel = lim_lo[i*SAMPLE_W +: SAMPLE_W];
                hi_sel = lim_hi[i*SAMPLE_W +: SAMPLE_W];
                ch_ok  = 1'b1;
            end
        end
    end

    // Inclusive signed window test.
    always_comb begin
        in_range = ch_ok && ($signed(data) >= lo_sel) && ($signed(data) <= hi_sel);
    end
endmodule

// File: rtl/tqi_qual_counter.sv
`timescale 1ns/1ps
// Module tqi_qual_counter: counts consecutive in-range samples of one source
// and reports fire on the sample that completes the programmed run.
// A need of 0 acts as 1. Out-of-range samples restart the run. With
// RESTART = 1 the run restarts after firing; otherwise it saturates so
// every further in-range sample fires again. Holds while hit is low.
module tqi_qual_counter #(
    parameter int CNT_W   = 4,
    parameter bit RESTART = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             in_range,
    input  logic [CNT_W-1:0] need,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   need_eff;

    // Run length reached by this sample and the effective target.
    always_comb begin
        cnt_inc  = {1'b0, cnt} + 1'b1;
        need_eff = (need == '0) ? (CNT_W+1)'(1) : {1'b0, need};
        fire     = hit && in_range && (cnt_inc >= need_eff);
    end

    // Advance, restart or hold the run count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hit) begin
            if (!in_range)
                cnt <= '0;
            else if (fire)
                cnt <= RESTART ? '0 : cnt;
            else
                cnt <= cnt_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/tqi_regs.sv
`timescale 1ns/1ps
// Module tqi_regs: holds the per-channel status bits and the filter byte,
// decodes register writes (write-one-to-clear on status words) and builds
// the read data. A set in the same cycle as a clear or wipe wins.
// Assumes WORD_W >= 8 and status words at consecutive 16-bit addresses.
module tqi_regs
    import tqi_pkg::*;
#(
    parameter int NUM_CH = 48,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_vec,
    input  logic              wipe,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic              busy_in,
    input  logic              acq_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output filt_t             filt,
    output logic [NUM_CH-1:0] status,
    output logic              irq
);
    localparam int NUM_WORDS = (NUM_CH + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    logic [PAD_W-1:0]  clr_pad;
    logic [PAD_W-1:0]  stat_pad;
    logic [NUM_CH-1:0] clr_vec;

    // Decode a status-word write into a per-channel clear mask.
    always_comb begin
        clr_pad = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_we && reg_addr == ADDR_W'(STAT_BASE + 2*w))
                clr_pad[w*WORD_W +: WORD_W] = reg_wdata;
        end
        clr_vec = clr_pad[NUM_CH-1:0];
    end

    // Status bits: clear by write or wipe, set by qualified events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_vec & ~{NUM_CH{wipe}}) | set_vec;
    end

    // Filter byte written at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            filt <= '0;
        else if (reg_we && reg_addr == FILT_ADDR)
            filt <= reg_wdata[7:0];
    end

    // Interrupt line from enabled, pending channels.
    always_comb begin
        irq = |(status & ch_enable);
    end

    // Read data multiplexer.
    always_comb begin
        stat_pad = '0;
        stat_pad[NUM_CH-1:0] = status;
        reg_rdata = '0;
        if (reg_addr == FILT_ADDR)
            reg_rdata[7:0] = filt;
        if (reg_addr == CTRL_ADDR)
            reg_rdata[2:0] = {acq_en, busy_in, irq};
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_addr == ADDR_W'(STAT_BASE + 2*w))
                reg_rdata = stat_pad[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/tqi_ctrl.sv
`timescale 1ns/1ps
// Module tqi_ctrl: qualified threshold interrupt controller. One comparator
// tests the incoming sample against its channel's limits; one run counter
// per channel qualifies the status flag and one more qualifies the
// acquisition trigger. Assumes at most one sample per cycle.
module tqi_ctrl
    import tqi_pkg::*;
#(
    parameter int NUM_CH   = 48,
    parameter int SAMPLE_W = 16,
    parameter int WORD_W   = 16,
    parameter int CNT_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic [$clog2(NUM_CH)-1:0]  sample_ch,
    input  logic [SAMPLE_W-1:0]        sample_data,
    input  logic [NUM_CH*SAMPLE_W-1:0] lim_lo,
    input  logic [NUM_CH*SAMPLE_W-1:0] lim_hi,
    input  logic [NUM_CH-1:0]          ch_enable,
    input  logic [$clog2(NUM_CH)-1:0]  trig_ch,
    input  logic                       acq_en,
    input  logic                       busy_in,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [WORD_W-1:0]          reg_wdata,
    output logic [WORD_W-1:0]          reg_rdata,
    output logic                       irq,
    output logic                       acq_start
);
    localparam int CH_W = $clog2(NUM_CH);

    logic              ch_ok;
    logic              in_range;
    logic              trig_hit;
    logic              trig_fire;
    logic [NUM_CH-1:0] set_vec;
    logic [NUM_CH-1:0] status;
    filt_t             filt;

    tqi_range_cmp #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) u_cmp (
        .ch(sample_ch), .data(sample_data), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .ch_ok(ch_ok), .in_range(in_range)
    );

    // One saturating run counter per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic hit;
        always_comb hit = sample_valid && ch_ok && ch_enable[i] && (sample_ch == CH_W'(i));
        tqi_qual_counter #(.CNT_W(CNT_W), .RESTART(1'b0)) u_qual (
            .clk(clk), .rst_n(rst_n), .hit(hit), .in_range(in_range),
            .need(filt.flag_need), .fire(set_vec[i])
        );
    end

    // Trigger source: the selected channel while arming is on.
    always_comb begin
        trig_hit = sample_valid && ch_ok && acq_en && (sample_ch == trig_ch);
    end

    tqi_qual_counter #(.CNT_W(CNT_W), .RESTART(1'b1)) u_trig (
        .clk(clk), .rst_n(rst_n), .hit(trig_hit), .in_range(in_range),
        .need(filt.trig_need), .fire(trig_fire)
    );

    // Start pulse follows the qualifying sample by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acq_start <= 1'b0;
        else
            acq_start <= trig_fire;
    end

    tqi_regs #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wipe(trig_fire),
        .ch_enable(ch_enable), .busy_in(busy_in), .acq_en(acq_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .filt(filt), .status(status), .irq(irq)
    );
endmodule

// File: rtl/tqi_ctrl_chk.sv
`timescale 1ns/1ps
// Module tqi_ctrl_chk: temporal properties of the controller, bound to it.
module tqi_ctrl_chk #(
    parameter int NUM_CH = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] set_vec,
    input logic              trig_fire,
    input logic [NUM_CH-1:0] status,
    input logic [NUM_CH-1:0] ch_enable,
    input logic              irq,
    input logic              acq_start,
    input logic              acq_en,
    input logic              reg_we,
    input logic [7:0]        reg_addr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata
);
    // A qualified event is visible in status after the edge, whatever else happens.
    assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // Disabled channels never gain a status bit.
    assert_no_disabled_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(ch_enable)) == '0));

    // A clear of word 0 with no competing event empties the written bits.
    assert_w1c_word0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h18 && set_vec[15:0] == '0 && !trig_fire)
        |=> ((status[15:0] & $past(reg_wdata)) == '0));

    // Trigger wipe with no simultaneous event leaves nothing pending.
    assert_start_wipes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_fire && set_vec == '0) |=> (status == '0 && !irq));

    // The start pulse only follows an armed cycle.
    assert_start_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |-> $past(acq_en));

    // The interrupt line implies a pending flag.
    assert_irq_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    // Control word: reserved bits zero, bit 0 mirrors the line.
    assert_ctrl_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h20) |-> (reg_rdata[15:3] == '0 && reg_rdata[0] == irq));
endmodule

bind tqi_ctrl tqi_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .trig_fire(trig_fire),
    .status(status), .ch_enable(ch_enable), .irq(irq), .acq_start(acq_start),
    .acq_en(acq_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/test_tqi_ctrl.sv
`timescale 1ns/1ps
// Bench for tqi_ctrl: directed corner cases, then seeded random traffic,
// all compared against a behavioural model kept in bench functions.
module test_tqi_ctrl;
    localparam int NCH = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_valid = 1'b0;
    logic [5:0]   sample_ch = '0;
    logic [15:0]  sample_data = '0;
    logic [NCH*16-1:0] lim_lo;
    logic [NCH*16-1:0] lim_hi;
    logic [NCH-1:0] ch_enable = '1;
    logic [5:0]   trig_ch = '0;
    logic         acq_en = 1'b0;
    logic         busy_in = 1'b0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         irq;
    logic         acq_start;

    int lo_m [NCH];
    int hi_m [NCH];
    int cnt_m [NCH];
    int tcnt_m;
    logic [NCH-1:0] st_m;
    logic [7:0] filt_m;
    logic exp_start;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tqi_ctrl i_tqi_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_ch(sample_ch),
        .sample_data(sample_data), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .ch_enable(ch_enable), .trig_ch(trig_ch), .acq_en(acq_en), .busy_in(busy_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .acq_start(acq_start)
    );

    // Pack the model limits onto the limit buses.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            lim_lo[i*16 +: 16] = 16'(lo_m[i]);
            lim_hi[i*16 +: 16] = 16'(hi_m[i]);
        end
    end

    function automatic logic exp_irq();
        return |(st_m & ch_enable);
    endfunction

    function automatic logic [15:0] exp_read(int addr);
        case (addr)
            'h16: return {8'h00, filt_m};
            'h18: return st_m[15:0];
            'h1A: return st_m[31:16];
            'h1C: return st_m[47:32];
            'h20: return {13'h0, acq_en, busy_in, exp_irq()};
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Advance the model by one edge with the given stimulus.
    task automatic model_step(bit v, int ch, int d, bit we, int addr, int wd);
        logic [NCH-1:0] setv = '0;
        logic [NCH-1:0] clrv = '0;
        bit fire = 0;
        int need  = (filt_m[3:0] == 0) ? 1 : int'(filt_m[3:0]);
        int tneed = (filt_m[7:4] == 0) ? 1 : int'(filt_m[7:4]);
        if (v && ch < NCH) begin
            bit inr = (d >= lo_m[ch]) && (d <= hi_m[ch]);
            if (ch_enable[ch]) begin
                if (!inr) cnt_m[ch] = 0;
                else if (cnt_m[ch] + 1 >= need) setv[ch] = 1'b1;
                else cnt_m[ch]++;
            end
            if (acq_en && ch == int'(trig_ch)) begin
                if (!inr) tcnt_m = 0;
                else if (tcnt_m + 1 >= tneed) begin fire = 1; tcnt_m = 0; end
                else tcnt_m++;
            end
        end
        if (we) begin
            case (addr)
                'h18: clrv[15:0]  = wd[15:0];
                'h1A: clrv[31:16] = wd[15:0];
                'h1C: clrv[47:32] = wd[15:0];
                default: ;
            endcase
        end
        st_m = (st_m & ~clrv & ~{NCH{fire}}) | setv;
        exp_start = fire;
        if (we && addr == 'h16) filt_m = wd[7:0];
    endtask

    // One clock: drive, clock, then read back one register and check outputs.
    task automatic cycle(bit v, int ch, int d, bit we, int addr, int wd, int raddr, string tag);
        @(negedge clk);
        sample_valid = v; sample_ch = 6'(ch); sample_data = 16'(d);
        reg_we = we; reg_addr = 8'(addr); reg_wdata = 16'(wd);
        model_step(v, ch, d, we, addr, wd);
        @(posedge clk);
        #1;
        sample_valid = 0; reg_we = 0; reg_addr = 8'(raddr);
        #1;
        check(tag, "irq", {15'h0, irq}, {15'h0, exp_irq()});
        check(tag, "acq_start", {15'h0, acq_start}, {15'h0, exp_start});
        check(tag, "rdata", reg_rdata, exp_read(raddr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NCH; i++) begin
            lo_m[i] = int'($urandom_range(0, 2000)) - 1000;
            hi_m[i] = lo_m[i] + int'($urandom_range(0, 600)) - 50;
            cnt_m[i] = 0;
        end
        lo_m[5] = -100; hi_m[5] = 200;
        lo_m[7] = 0;    hi_m[7] = 10;
        lo_m[40] = -5;  hi_m[40] = 5;
        tcnt_m = 0; st_m = '0; filt_m = '0; exp_start = 0;

        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R11: reset state
        check("R11", "irq", {15'h0, irq}, 16'h0);
        check("R11", "acq_start", {15'h0, acq_start}, 16'h0);
        reg_addr = 8'h18; #0.5; check("R11", "word0", reg_rdata, 16'h0);
        reg_addr = 8'h16; #0.5; check("R11", "filter", reg_rdata, 16'h0);

        // R10: filter write and read back, upper byte ignored
        cycle(0, 0, 0, 1, 'h16, 'hFF23, 'h16, "R10");
        // R1 and R2: run of three, broken by an out-of-range sample
        cycle(1, 5, -100, 0, 0, 0, 'h18, "R1");
        cycle(1, 5, 200, 0, 0, 0, 'h18, "R2");
        cycle(1, 5, 201, 0, 0, 0, 'h18, "R1");
        cycle(1, 5, 0, 0, 0, 0, 'h18, "R2");
        cycle(1, 5, 0, 0, 0, 0, 'h18, "R2");
        cycle(1, 5, 50, 0, 0, 0, 'h18, "R2");
        cycle(1, 5, -101, 0, 0, 0, 'h18, "R1");
        cycle(1, 53, 0, 0, 0, 0, 'h18, "R1");
        // R6: write zero keeps, write one clears
        cycle(0, 0, 0, 1, 'h18, 'h0000, 'h18, "R6");
        cycle(0, 0, 0, 1, 'h18, 'h0020, 'h18, "R6");
        for (int k = 0; k < 3; k++) cycle(1, 5, 10, 0, 0, 0, 'h18, "R2");
        cycle(1, 5, 10, 1, 'h18, 'h0020, 'h18, "R6");
        // R4: disabled channel ignores samples, run count held
        ch_enable[7] = 1'b0;
        for (int k = 0; k < 4; k++) cycle(1, 7, 5, 0, 0, 0, 'h18, "R4");
        ch_enable[7] = 1'b1;
        cycle(1, 7, 5, 0, 0, 0, 'h18, "R4");
        cycle(0, 0, 0, 1, 'h18, 'hFFFF, 'h18, "R6");
        // R3 and R5: zero run length, upper word
        cycle(0, 0, 0, 1, 'h16, 'h0000, 'h16, "R10");
        cycle(1, 40, 5, 0, 0, 0, 'h1C, "R3");
        cycle(1, 20, lo_m[20], 0, 0, 0, 'h1A, "R5");
        // R8 and R9: trigger on a disabled channel, two samples
        cycle(0, 0, 0, 1, 'h16, 'h0020, 'h16, "R10");
        ch_enable[7] = 1'b0; trig_ch = 6'd7; acq_en = 1'b1;
        cycle(1, 7, 3, 0, 0, 0, 'h20, "R8");
        cycle(1, 7, 3, 0, 0, 0, 'h1C, "R9");
        cycle(1, 7, 3, 0, 0, 0, 'h1C, "R8");
        cycle(1, 7, 30, 0, 0, 0, 'h20, "R8");
        // R7: control word with busy and unmapped address
        busy_in = 1'b1;
        cycle(1, 40, 0, 0, 0, 0, 'h20, "R7");
        cycle(0, 0, 0, 0, 0, 0, 'h22, "R7");
        ch_enable[7] = 1'b1;

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int ch = ($urandom_range(0, 15) == 0) ? int'($urandom_range(48, 63))
                                                  : int'($urandom_range(0, 47));
            int d;
            int ra;
            int op = int'($urandom_range(0, 19));
            if (ch < NCH) begin
                d = (($urandom_range(0, 1) != 0) ? lo_m[ch] : hi_m[ch]) + int'($urandom_range(0, 6)) - 3;
                if ($urandom_range(0, 3) == 0) d = lo_m[ch] + int'($urandom_range(0, 100));
            end else d = 0;
            if (op == 0) begin
                acq_en = $urandom_range(0, 1) != 0;
                trig_ch = 6'($urandom_range(0, 47));
            end
            if (op == 1) busy_in = ~busy_in;
            if (op == 2) ch_enable[$urandom_range(0, 47)] ^= 1'b1;
            ra = 'h16 + 2 * int'($urandom_range(0, 6));
            case (op)
                3, 4, 5: cycle(1, ch, d, 1, 'h18 + 2 * int'($urandom_range(0, 2)),
                               int'($urandom_range(0, 65535)), ra, "R6");
                6:       cycle(1, ch, d, 1, 'h16, int'($urandom_range(0, 255)) & 'h33, ra, "R10");
                default: cycle(1, ch, d, 0, 0, 0, ra, "R2");
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule